// File: doc/BRIEF.md
# Systolic Partial-Sum Tile for Split Recurrent Layers

This tile is one cell of a two-dimensional grid that shares the work of a single large recurrent weight matrix. Each tile keeps a `ROWS x SLICE` block of 8-bit weights in local registers. A slice of the layer's input vector arrives on the north stream, and the tile passes an unchanged copy out on its south stream one cycle later. Partial sums for `ROWS` output rows arrive on the west stream. The tile adds its own block product to those sums and sends the new sums out on its east stream. Only input slices, which move down the columns, and short partial-sum vectors, which move along the rows, travel between tiles. Weights never leave the tile that holds them.

A tile built with `FIRST_COL` set has no upstream neighbour. It ignores its west stream and starts every row from a locally stored bias. A tile built with `LAST_COL` set sends out the finished pre-activations. In the same beat it gives a clipped-linear activation of each row: the 8-bit hidden state that the system feeds back to the top of the grid as the recurrent part of the next input vector. Inside a tile, one multiply-accumulate lane per output row steps through the slice elements one per cycle.

Top module: `psum_tile`

## Requirements
- R1: After reset, `southValid` and `eastValid` are low and `hiddenData` is zero. A first-column tile shows `northReady` high. A tile that is not first-column shows `northReady` low while `westValid` is low.
- R2: A write with `wrEn` high stores `wrData` as a weight when `wrAddr` is `r*SLICE+k`, which is row `r` and slice element `k`. It stores `wrData` as the bias of row `r` when `wrAddr` is `ROWS*SLICE+r`. Higher addresses are ignored.
- R3: A tile that is not first-column accepts a north slice and a west sum vector only together. It does so in a cycle where `northValid`, `northReady`, `westValid` and `westReady` are all high, and `northReady` never rises while `westValid` is low.
- R4: An accepted slice appears unchanged on `southData`, with `southValid` high, in the cycle after it is accepted. It stays there until `southReady` is high.
- R5: For an accepted slice `x` and west vector `p`, the tile raises `eastValid` SLICE+1 cycles after acceptance. Row `r` of `eastData` (bits `r*PSUM_W` upward) is then `p[r] + sum_k W[r][k]*x[k]`, where slice element `k` is `northData[k*DATA_W +: DATA_W]`. All values are two's complement.
- R6: A first-column tile holds `westReady` low, ignores `westValid` and `westData`, and uses the stored bias of each row in place of `p[r]`.
- R7: Each row of `eastData` is saturated to the range -32768 to 32767 of a 16-bit signed value.
- R8: In a last-column tile, row `r` of `hiddenData` (bits `r*DATA_W` upward) is the row's `eastData` value shifted arithmetically right by `ACT_SHIFT`, then saturated to -128 to 127. It is valid with `eastValid`. A tile that is not last-column drives `hiddenData` to zero.
- R9: While `eastValid` is high and `eastReady` is low, `eastValid` stays high, `eastData` holds its value, and `northReady` is low.
- R10: In a grid of tiles, the hidden state from the last column, fed back as the next input vector, produces the layer's next-step result without any tile seeing more than its own weight block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| wrEn | input | 1 | Weight/bias write strobe |
| wrAddr | input | ADDR_W | Weight/bias write address |
| wrData | input | DATA_W | Weight/bias write value |
| northValid | input | 1 | Input slice valid |
| northReady | output | 1 | Input slice accepted |
| northData | input | SLICE*DATA_W | Input slice elements |
| southValid | output | 1 | Forwarded slice valid |
| southReady | input | 1 | Downstream accepts slice |
| southData | output | SLICE*DATA_W | Forwarded slice |
| westValid | input | 1 | Incoming partial sums valid |
| westReady | output | 1 | Incoming partial sums accepted |
| westData | input | ROWS*PSUM_W | Incoming partial sums |
| eastValid | output | 1 | Outgoing sums valid |
| eastReady | input | 1 | Downstream accepts sums |
| eastData | output | ROWS*PSUM_W | Outgoing partial sums or pre-activations |
| hiddenData | output | ROWS*DATA_W | Activated hidden state, last column only |

## Verification
The bench builds a 2x2 grid with the default sizes: four rows by four slice elements per tile, 8-bit data, 16-bit sums and a shift of 7. One instance per grid position selects the first-column and last-column variants. This setting lets a full eight-element input vector and its eight hidden outputs circulate, so the second step's input is the first step's hidden state. It also brings within reach the join between a horizontal and a vertical stream, saturation in both directions through two hops, and a stalled last column pushing back on the grid.

// File: rtl/tile_pkg.sv
package tile_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MAC  = 2'd1,
    ST_OUT  = 2'd2
  } tileState_e;

  typedef struct packed {
    logic capture;
    logic macEn;
  } tileStrobe_t;

endpackage

// File: rtl/tile_ctrl.sv
module tile_ctrl
  import tile_pkg::*;
#(
  parameter int SLICE     = 4,
  parameter bit FIRST_COL = 1'b0,
  localparam int IW       = (SLICE > 1) ? $clog2(SLICE) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          northValid,
  output logic          northReady,
  input  logic          westValid,
  output logic          westReady,
  output logic          southValid,
  input  logic          southReady,
  output logic          eastValid,
  input  logic          eastReady,
  output tileStrobe_t   strobe,
  output logic [IW-1:0] macIdx
);

  tileState_e state;
  logic [IW-1:0] idx;
  logic southFree;
  logic idle;
  logic capture;

  always_comb begin
    southFree  = !southValid || southReady;
    idle       = (state == ST_IDLE);
    northReady = idle && southFree && (FIRST_COL || westValid);
    westReady  = FIRST_COL ? 1'b0 : (idle && southFree && northValid);
    capture    = northValid && northReady;
    strobe.capture = capture;
    strobe.macEn   = (state == ST_MAC);
    eastValid  = (state == ST_OUT);
    macIdx     = idx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      idx         <= '0;
      southValid  <= 1'b0;
    end else begin
      if (capture) begin
        southValid <= 1'b1;
      end else if (southReady) begin
        southValid <= 1'b0;
      end
      case (state)
        ST_IDLE: begin
          if (capture) begin
            state <= ST_MAC;
            idx   <= '0;
          end
        end
        ST_MAC: begin
          if (idx == IW'(SLICE - 1)) begin
            state <= ST_OUT;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_OUT: begin
          if (eastReady) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: a middle or last column consumes north only together with west
  assert_join_R3: assert property (@(posedge clk) disable iff (!rstN)
    (northValid && northReady && !FIRST_COL) |-> (westValid && westReady))
    else $error("north accepted without west");

  // R4: accepted slice is presented south on the next cycle
  assert_south_next_R4: assert property (@(posedge clk) disable iff (!rstN)
    (northValid && northReady) |=> southValid)
    else $error("south not valid after accept");

  // R5: result is never presented in the cycle right after acceptance
  assert_east_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    (northValid && northReady) |=> !eastValid)
    else $error("east valid too early");

  // R9: a stalled result stays valid
  assert_east_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (eastValid && !eastReady) |=> eastValid)
    else $error("east valid dropped under stall");

  // R9: no new slice while a result waits
  assert_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    eastValid |-> !northReady)
    else $error("north ready while east pending");

endmodule

// File: rtl/tile_dp.sv
module tile_dp
  import tile_pkg::*;
#(
  parameter int ROWS      = 4,
  parameter int SLICE     = 4,
  parameter int DATA_W    = 8,
  parameter int PSUM_W    = 16,
  parameter int ACT_SHIFT = 7,
  parameter bit FIRST_COL = 1'b0,
  parameter bit LAST_COL  = 1'b0,
  localparam int IW       = (SLICE > 1) ? $clog2(SLICE) : 1,
  localparam int ADDR_W   = $clog2(ROWS * SLICE + ROWS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [SLICE*DATA_W-1:0]  northData,
  input  logic [ROWS*PSUM_W-1:0]   westData,
  input  tileStrobe_t              strobe,
  input  logic [IW-1:0]            macIdx,
  output logic [SLICE*DATA_W-1:0]  southData,
  output logic [ROWS*PSUM_W-1:0]   eastData,
  output logic [ROWS*DATA_W-1:0]   hiddenData
);

  localparam int PROD_W = 2 * DATA_W;
  localparam int WIDE_W = (PSUM_W > PROD_W) ? PSUM_W : PROD_W;
  localparam int ACC_W  = WIDE_W + $clog2(SLICE + 1) + 2;

  logic signed [DATA_W-1:0] weightMem [ROWS][SLICE];
  logic signed [DATA_W-1:0] biasMem   [ROWS];
  logic signed [DATA_W-1:0] sliceReg  [SLICE];
  logic signed [ACC_W-1:0]  acc       [ROWS];
  logic signed [PROD_W-1:0] prod      [ROWS];
  logic [SLICE*DATA_W-1:0]  southReg;

  // weight and bias storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++) begin
        biasMem[r] <= '0;
        for (int k = 0; k < SLICE; k++) weightMem[r][k] <= '0;
      end
    end else if (wrEn) begin
      for (int r = 0; r < ROWS; r++) begin
        if (wrAddr == ADDR_W'(ROWS * SLICE + r)) biasMem[r] <= wrData;
        for (int k = 0; k < SLICE; k++) begin
          if (wrAddr == ADDR_W'(r * SLICE + k)) weightMem[r][k] <= wrData;
        end
      end
    end
  end

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      prod[r] = weightMem[r][macIdx] * sliceReg[macIdx];
    end
  end

  // slice capture, south copy and per-row accumulation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      southReg <= '0;
      for (int k = 0; k < SLICE; k++) sliceReg[k] <= '0;
      for (int r = 0; r < ROWS; r++) acc[r] <= '0;
    end else if (strobe.capture) begin
      southReg <= northData;
      for (int k = 0; k < SLICE; k++) sliceReg[k] <= northData[k*DATA_W +: DATA_W];
      for (int r = 0; r < ROWS; r++) begin
        if (FIRST_COL) begin
          acc[r] <= {{(ACC_W-DATA_W){biasMem[r][DATA_W-1]}}, biasMem[r]};
        end else begin
          acc[r] <= {{(ACC_W-PSUM_W){westData[r*PSUM_W+PSUM_W-1]}},
                     westData[r*PSUM_W +: PSUM_W]};
        end
      end
    end else if (strobe.macEn) begin
      for (int r = 0; r < ROWS; r++) begin
        acc[r] <= acc[r] + {{(ACC_W-PROD_W){prod[r][PROD_W-1]}}, prod[r]};
      end
    end
  end

  assign southData = southReg;

  localparam logic signed [ACC_W-1:0] PMAX = {{(ACC_W-PSUM_W+1){1'b0}}, {(PSUM_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] PMIN = {{(ACC_W-PSUM_W+1){1'b1}}, {(PSUM_W-1){1'b0}}};
  localparam logic signed [PSUM_W-1:0] HMAX = {{(PSUM_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [PSUM_W-1:0] HMIN = {{(PSUM_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  for (genvar r = 0; r < ROWS; r++) begin : gRow
    logic signed [PSUM_W-1:0] satRow;
    always_comb begin
      if (acc[r] > PMAX)      satRow = PMAX[PSUM_W-1:0];
      else if (acc[r] < PMIN) satRow = PMIN[PSUM_W-1:0];
      else                    satRow = acc[r][PSUM_W-1:0];
    end
    assign eastData[r*PSUM_W +: PSUM_W] = satRow;

    if (LAST_COL) begin : gAct
      logic signed [PSUM_W-1:0] shifted;
      logic signed [DATA_W-1:0] actRow;
      always_comb begin
        shifted = satRow >>> ACT_SHIFT;
        if (shifted > HMAX)      actRow = HMAX[DATA_W-1:0];
        else if (shifted < HMIN) actRow = HMIN[DATA_W-1:0];
        else                     actRow = shifted[DATA_W-1:0];
      end
      assign hiddenData[r*DATA_W +: DATA_W] = actRow;
    end else begin : gNoAct
      assign hiddenData[r*DATA_W +: DATA_W] = '0;
    end
  end

  // R4: south carries exactly the slice that was captured
  assert_south_copy_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (southData == $past(northData)))
    else $error("south data differs from captured slice");

  // R9: sums do not move unless captured or accumulated
  assert_sum_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.capture && !strobe.macEn) |=> $stable(eastData))
    else $error("east data moved without strobe");

endmodule

// File: rtl/psum_tile.sv
module psum_tile
  import tile_pkg::*;
#(
  parameter int ROWS      = 4,
  parameter int SLICE     = 4,
  parameter int DATA_W    = 8,
  parameter int PSUM_W    = 16,
  parameter int ACT_SHIFT = 7,
  parameter bit FIRST_COL = 1'b0,
  parameter bit LAST_COL  = 1'b0,
  localparam int ADDR_W   = $clog2(ROWS * SLICE + ROWS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic                     northValid,
  output logic                     northReady,
  input  logic [SLICE*DATA_W-1:0]  northData,
  output logic                     southValid,
  input  logic                     southReady,
  output logic [SLICE*DATA_W-1:0]  southData,
  input  logic                     westValid,
  output logic                     westReady,
  input  logic [ROWS*PSUM_W-1:0]   westData,
  output logic                     eastValid,
  input  logic                     eastReady,
  output logic [ROWS*PSUM_W-1:0]   eastData,
  output logic [ROWS*DATA_W-1:0]   hiddenData
);

  localparam int IW = (SLICE > 1) ? $clog2(SLICE) : 1;

  tileStrobe_t strobe;
  logic [IW-1:0] macIdx;

  tile_ctrl #(
    .SLICE(SLICE), .FIRST_COL(FIRST_COL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .northValid(northValid), .northReady(northReady),
    .westValid(westValid), .westReady(westReady),
    .southValid(southValid), .southReady(southReady),
    .eastValid(eastValid), .eastReady(eastReady),
    .strobe(strobe), .macIdx(macIdx)
  );

  tile_dp #(
    .ROWS(ROWS), .SLICE(SLICE), .DATA_W(DATA_W), .PSUM_W(PSUM_W),
    .ACT_SHIFT(ACT_SHIFT), .FIRST_COL(FIRST_COL), .LAST_COL(LAST_COL)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .northData(northData), .westData(westData),
    .strobe(strobe), .macIdx(macIdx),
    .southData(southData), .eastData(eastData), .hiddenData(hiddenData)
  );

endmodule

// File: tb/psum_tile_bench.sv
`timescale 1ns/1ps
module psum_tile_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;

  logic [4:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        wrEn   [2][2];

  logic        nV [2][2]; logic nR [2][2]; logic [31:0] nD [2][2];
  logic        sV [2][2]; logic sR [2][2]; logic [31:0] sD [2][2];
  logic        wV [2][2]; logic wR [2][2]; logic [63:0] wD [2][2];
  logic        eV [2][2]; logic eR [2][2]; logic [63:0] eD [2][2];
  logic [31:0] hD [2][2];

  logic        drvNV [2];
  logic [31:0] drvND [2];
  logic        eastRdy = 1'b1;

  for (genvar r = 0; r < 2; r++) begin : gR
    for (genvar c = 0; c < 2; c++) begin : gC
      if (r == 0) begin : gTop
        assign nV[r][c] = drvNV[c];
        assign nD[r][c] = drvND[c];
        assign sR[r][c] = nR[1][c];
      end else begin : gBot
        assign nV[r][c] = sV[0][c];
        assign nD[r][c] = sD[0][c];
        assign sR[r][c] = 1'b1;
      end
      if (c == 0) begin : gLeft
        assign wV[r][c] = 1'b1;
        assign wD[r][c] = 64'h7FFF_7FFF_7FFF_7FFF;
        assign eR[r][c] = wR[r][1];
      end else begin : gRight
        assign wV[r][c] = eV[r][0];
        assign wD[r][c] = eD[r][0];
        assign eR[r][c] = eastRdy;
      end
      psum_tile #(.FIRST_COL(c == 0), .LAST_COL(c == 1)) u_psum_tile (
        .clk(clk), .rstN(rstN),
        .wrEn(wrEn[r][c]), .wrAddr(wrAddr), .wrData(wrData),
        .northValid(nV[r][c]), .northReady(nR[r][c]), .northData(nD[r][c]),
        .southValid(sV[r][c]), .southReady(sR[r][c]), .southData(sD[r][c]),
        .westValid(wV[r][c]), .westReady(wR[r][c]), .westData(wD[r][c]),
        .eastValid(eV[r][c]), .eastReady(eR[r][c]), .eastData(eD[r][c]),
        .hiddenData(hD[r][c])
      );
    end
  end

  int W [8][8];
  int B [8];
  int capHid [8];

  typedef struct packed { logic [63:0] p; logic [31:0] h; } item_t;
  item_t expQ0 [$];
  item_t expQ1 [$];

  function automatic int satv(int v, int bits);
    int hi = (1 << (bits - 1)) - 1;
    int lo = -(1 << (bits - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeTile(int r, int c, int addr, int val);
    @(negedge clk);
    wrEn[r][c] = 1'b1; wrAddr = 5'(addr); wrData = 8'(val);
    @(negedge clk);
    wrEn[r][c] = 1'b0;
  endtask

  // R2: weight W[r][k] at r*4+k, bias of row r at 16+r
  task automatic loadAll();
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 2; c++) begin
        for (int i = 0; i < 4; i++) begin
          for (int k = 0; k < 4; k++) writeTile(r, c, i*4 + k, W[r*4+i][c*4+k]);
          if (c == 0) writeTile(r, c, 16 + i, B[r*4+i]);
        end
      end
    writeTile(0, 0, 25, 99); // R2: out-of-map address, must be ignored
  endtask

  task automatic driveCol(int c, logic [31:0] data);
    @(negedge clk);
    drvNV[c] = 1'b1; drvND[c] = data;
    #1;
    while (!nR[0][c]) begin @(negedge clk); #1; end
    @(negedge clk);
    drvNV[c] = 1'b0;
  endtask

  task automatic sendVec(int x [8]);
    item_t it0, it1;
    logic [31:0] s0, s1;
    for (int o = 0; o < 8; o++) begin
      int p = B[o];
      for (int k = 0; k < 4; k++) p += W[o][k] * x[k];
      p = satv(p, 16);
      for (int k = 4; k < 8; k++) p += W[o][k] * x[k];
      p = satv(p, 16);
      if (o < 4) begin
        it0.p[(o%4)*16 +: 16] = 16'(p);
        it0.h[(o%4)*8 +: 8]   = 8'(satv(p >>> 7, 8));
      end else begin
        it1.p[(o%4)*16 +: 16] = 16'(p);
        it1.h[(o%4)*8 +: 8]   = 8'(satv(p >>> 7, 8));
      end
    end
    expQ0.push_back(it0);
    expQ1.push_back(it1);
    for (int k = 0; k < 4; k++) begin
      s0[k*8 +: 8] = 8'(x[k]);
      s1[k*8 +: 8] = 8'(x[k+4]);
    end
    fork
      driveCol(0, s0);
      driveCol(1, s1);
    join
  endtask

  task automatic waitDrain();
    while (expQ0.size() != 0 || expQ1.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // scoreboard monitor: R5, R7, R8, R10
  logic        prevAcc = 1'b0;
  logic [31:0] prevData = '0;
  always @(negedge clk) begin
    #2;
    if (rstN) begin
      for (int rb = 0; rb < 2; rb++) begin
        if (eV[rb][1] && eastRdy) begin
          item_t it;
          if ((rb == 0 && expQ0.size() == 0) || (rb == 1 && expQ1.size() == 0)) begin
            check(1'b0, "R5 unexpected result", eD[rb][1], 64'h0);
          end else begin
            it = (rb == 0) ? expQ0.pop_front() : expQ1.pop_front();
            check(eD[rb][1] == it.p, "R5/R7 pre-activation", eD[rb][1], it.p);
            check(hD[rb][1] == it.h, "R8 hidden", {32'h0, hD[rb][1]}, {32'h0, it.h});
            for (int i = 0; i < 4; i++) capHid[rb*4+i] = int'($signed(hD[rb][1][i*8 +: 8]));
          end
        end
      end
      // R4: forwarded slice one cycle after acceptance
      if (prevAcc) begin
        check(sV[0][0] && sD[0][0] == prevData, "R4 south forward",
              {31'h0, sV[0][0], sD[0][0]}, {32'h1, prevData});
      end
      prevAcc  = nV[0][0] && nR[0][0];
      prevData = nD[0][0];
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int x [8];
    logic [63:0] hold0;
    for (int r = 0; r < 2; r++) for (int c = 0; c < 2; c++) wrEn[r][c] = 1'b0;
    drvNV[0] = 1'b0; drvNV[1] = 1'b0; drvND[0] = '0; drvND[1] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #2;
    // R1 reset state
    check(!eV[0][0] && !eV[0][1] && !eV[1][1], "R1 east idle", {61'h0, eV[0][0], eV[0][1], eV[1][1]}, 64'h0);
    check(!sV[0][0] && !sV[0][1], "R1 south idle", {62'h0, sV[0][0], sV[0][1]}, 64'h0);
    check(nR[0][0] == 1'b1, "R1 first column ready", {63'h0, nR[0][0]}, 64'h1);
    check(nR[0][1] == 1'b0, "R1/R3 middle tile waits for west", {63'h0, nR[0][1]}, 64'h0);
    check(hD[0][1] == 32'h0 && hD[0][0] == 32'h0, "R1/R8 hidden zero", {32'h0, hD[0][1]}, 64'h0);
    check(wR[0][0] == 1'b0, "R6 first column west not ready", {63'h0, wR[0][0]}, 64'h0);

    for (int o = 0; o < 8; o++) begin
      B[o] = o*3 - 10;
      for (int k = 0; k < 8; k++) W[o][k] = ((o*5 + k*3 + 2) % 9) - 4;
    end
    loadAll();

    // R5/R6: ordinary vector; first column's west carries 0x7FFF that must be ignored
    for (int k = 0; k < 8; k++) x[k] = k*5 - 17;
    sendVec(x);
    waitDrain();
    // R10: hidden state fed back as the next input
    for (int k = 0; k < 8; k++) x[k] = capHid[k];
    sendVec(x);
    waitDrain();
    // back-to-back vectors
    for (int k = 0; k < 8; k++) x[k] = 20 - k*6;
    sendVec(x);
    for (int k = 0; k < 8; k++) x[k] = (k % 2 == 0) ? 9 : -11;
    sendVec(x);
    waitDrain();

    // R9: stall the last column
    eastRdy = 1'b0;
    for (int k = 0; k < 8; k++) x[k] = k + 1;
    sendVec(x);
    while (!(eV[0][1] && eV[1][1])) @(negedge clk);
    #2;
    hold0 = eD[0][1];
    repeat (8) @(negedge clk);
    #2;
    check(eV[0][1] && eD[0][1] == hold0, "R9 stalled east held", eD[0][1], hold0);
    check(nR[0][1] == 1'b0, "R9 no accept while stalled", {63'h0, nR[0][1]}, 64'h0);
    @(negedge clk);
    eastRdy = 1'b1;
    waitDrain();

    // R7: positive and negative saturation through both hops
    for (int o = 0; o < 8; o++) begin
      B[o] = 0;
      for (int k = 0; k < 8; k++) W[o][k] = 127;
    end
    loadAll();
    for (int k = 0; k < 8; k++) x[k] = 127;
    sendVec(x);
    waitDrain();
    for (int o = 0; o < 8; o++) for (int k = 0; k < 8; k++) W[o][k] = -128;
    loadAll();
    sendVec(x);
    waitDrain();

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule